// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps track of instructions that have been issued but not yet made permanent. Issue logic asks for a slot and receives the slot index as a tag. Execution results later come back on a result broadcast bus carrying that tag, and the matching slot records the value. Slots are retired from the oldest end one at a time, in the order they were handed out. A retiring slot does one of three things, chosen by its kind: it writes a register, it writes memory, or it resolves a branch. A branch whose prediction turned out wrong throws away every slot and asks fetch to restart at the corrected address.

Issue logic also uses the block as a rename source. A lookup port takes a producer tag and reports whether that producer's value is already known, even if the producer has not retired yet. A store can enter with its data missing. It then names the tag of the instruction that will produce the data and picks that value up from the broadcast bus.

The default depth is eight slots. Pointers wrap modulo the depth, and an occupancy counter tells full apart from empty.

Top module: `spec_rob`

## Requirements
- R1: `allocGrant` is high only when `allocReq` and `rsFree` are both high and the buffer is not full. `robFull` is high exactly when all DEPTH slots are occupied. No grant is given while `robFull` or `rsFree` is low.
- R2: A granted allocation returns in `allocTag` the index of the slot it takes. Tags start at 0 after reset, rise by one per grant and wrap from DEPTH-1 to 0.
- R3: For an occupied slot whose result has been recorded but which has not yet retired, `lookupReady` is high and `lookupValue` carries the recorded value.
- R4: When `cdbValid` is high with tag t, a waiting non-store slot t records `cdbValue` and becomes ready at that clock edge.
- R5: A store slot becomes ready either at issue, when `allocDataValid` is high, or by capturing `cdbValue` when `cdbTag` equals its `allocSrcTag`. A broadcast of that tag in the same cycle as the store's allocation counts as well.
- R6: Only the oldest slot can retire, and only once its result is present. At most one slot retires per cycle, so retirement follows allocation order. The retire outputs appear in the cycle after the edge that makes the oldest slot ready.
- R7: The kind field selects the retire action. Kind 2'b00 (normal) pulses `regWe` with `regAddr`/`regData`. Kind 2'b01 (store) pulses `memWe` with `memAddr`/`memData`. Kind 2'b10 (branch) with no misprediction retires with no visible write.
- R8: A branch slot that retires with its misprediction flag set (taken from `cdbMispredict` when its result arrived) raises `flush` for one cycle with `redirectPc` equal to the target from `cdbTarget`. No allocation is granted in that cycle. Afterwards every slot is empty, younger slots never retire, and the next tag handed out is 0.
- R9: When a broadcast and a lookup name the same tag in the same cycle, `lookupReady` is high and `lookupValue` equals `cdbValue` in that cycle.
- R10: During and right after reset, `robFull`, `regWe`, `memWe` and `flush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Issue logic requests a slot |
| rsFree | input | 1 | A reservation station is available |
| allocKind | input | 2 | Slot kind: 00 normal, 01 store, 10 branch |
| allocDest | input | REG_W | Destination register for a normal slot |
| allocStoreAddr | input | ADDR_W | Memory address for a store slot |
| allocDataValid | input | 1 | Store data is known at issue |
| allocData | input | DATA_W | Store data when known at issue |
| allocSrcTag | input | TAG_W | Producer tag of store data when not yet known |
| allocGrant | output | 1 | Allocation accepted this cycle |
| allocTag | output | TAG_W | Index of the slot being handed out |
| robFull | output | 1 | All slots occupied |
| lookupTag | input | TAG_W | Producer tag to inspect |
| lookupReady | output | 1 | Producer value is available |
| lookupValue | output | DATA_W | Producer value |
| cdbValid | input | 1 | Result broadcast present |
| cdbTag | input | TAG_W | Tag of broadcast result |
| cdbValue | input | DATA_W | Broadcast result value |
| cdbMispredict | input | 1 | Broadcast branch was mispredicted |
| cdbTarget | input | ADDR_W | Corrected target for a broadcast branch |
| regWe | output | 1 | Register write at retire |
| regAddr | output | REG_W | Register index written |
| regData | output | DATA_W | Register value written |
| memWe | output | 1 | Memory write at retire |
| memAddr | output | ADDR_W | Memory address written |
| memData | output | DATA_W | Memory data written |
| flush | output | 1 | Discard all slots and restart fetch |
| redirectPc | output | ADDR_W | Restart address during flush |

## Verification
The hardest case to reach is a flush that hits a full complement of younger, already finished slots. Their results have to be recorded while the mispredicted branch still blocks the oldest position, and then the branch result arrives last. The stimulus allocates the branch first, then broadcasts the younger results, and only then resolves the branch. A scoreboard expects the flush and nothing else, and afterwards lookups of those younger tags must report not ready. A second constructed situation broadcasts a store's data producer in the very cycle the store is allocated. A third fills all slots after the pointers have moved away from zero, so that wrap-around and the full flag are exercised together.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } entry_kind_e;

  // strobes handed from the control path to the slot storage
  typedef struct packed {
    logic allocEn;
    logic commitEn;
    logic flushEn;
  } rob_strobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocReq,
  input  logic             rsFree,
  input  logic             headBusy,
  input  logic             headReady,
  input  entry_kind_e      headKind,
  input  logic             headMispredict,
  output rob_strobe_t      strobe,
  output logic [TAG_W-1:0] headPtr,
  output logic [TAG_W-1:0] tailPtr,
  output logic             robFull
);

  logic [CNT_W-1:0] count;

  function automatic logic [TAG_W-1:0] stepPtr(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign robFull = (count == CNT_W'(DEPTH));

  always_comb begin
    strobe.commitEn = headBusy && headReady;
    strobe.flushEn  = strobe.commitEn && (headKind == KIND_BRANCH) && headMispredict;
    strobe.allocEn  = allocReq && rsFree && !robFull && !strobe.flushEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.flushEn) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.allocEn)  tailPtr <= stepPtr(tailPtr);
      if (strobe.commitEn) headPtr <= stepPtr(headPtr);
      count <= count + CNT_W'(strobe.allocEn) - CNT_W'(strobe.commitEn);
    end
  end

  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1: a full buffer refused a request, so the tail stays put
  a_r1_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
    robFull && allocReq && !strobe.flushEn |=> $stable(tailPtr));

  // R6: an ordinary retire advances the head by exactly one slot
  a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commitEn && !strobe.flushEn |=> headPtr == stepPtr($past(headPtr)));

  // R8: after a flush the buffer is empty with both pointers at zero
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flushEn |=> count == '0 && headPtr == '0 && tailPtr == '0);

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rob_strobe_t       strobe,
  input  logic [TAG_W-1:0]  headPtr,
  input  logic [TAG_W-1:0]  tailPtr,
  input  entry_kind_e       allocKind,
  input  logic [REG_W-1:0]  allocDest,
  input  logic [ADDR_W-1:0] allocStoreAddr,
  input  logic              allocDataValid,
  input  logic [DATA_W-1:0] allocData,
  input  logic [TAG_W-1:0]  allocSrcTag,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic              cdbMispredict,
  input  logic [ADDR_W-1:0] cdbTarget,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue,
  output logic              headBusy,
  output logic              headReady,
  output entry_kind_e       headKind,
  output logic              headMispredict,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic [ADDR_W-1:0] headAddr,
  output logic [ADDR_W-1:0] headTarget
);

  logic              busyQ   [DEPTH];
  logic              readyQ  [DEPTH];
  logic              mispQ   [DEPTH];
  entry_kind_e       kindQ   [DEPTH];
  logic [REG_W-1:0]  destQ   [DEPTH];
  logic [DATA_W-1:0] valueQ  [DEPTH];
  logic [ADDR_W-1:0] addrQ   [DEPTH];
  logic [ADDR_W-1:0] targetQ [DEPTH];
  logic [TAG_W-1:0]  waitQ   [DEPTH];

  // a store issued without data may see its producer on the bus this very cycle
  logic issueSnoop;
  assign issueSnoop = cdbValid && (cdbTag == allocSrcTag);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] SLOT = TAG_W'(i);
    logic allocHere, commitHere, ownHit, storeHit;

    assign allocHere  = strobe.allocEn && (tailPtr == SLOT);
    assign commitHere = strobe.commitEn && (headPtr == SLOT);
    assign ownHit     = cdbValid && (cdbTag == SLOT) && (kindQ[i] != KIND_STORE);
    assign storeHit   = cdbValid && (cdbTag == waitQ[i]) && (kindQ[i] == KIND_STORE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busyQ[i]   <= 1'b0;
        readyQ[i]  <= 1'b0;
        mispQ[i]   <= 1'b0;
        kindQ[i]   <= KIND_ALU;
        destQ[i]   <= '0;
        valueQ[i]  <= '0;
        addrQ[i]   <= '0;
        targetQ[i] <= '0;
        waitQ[i]   <= '0;
      end else if (strobe.flushEn) begin
        busyQ[i]  <= 1'b0;
        readyQ[i] <= 1'b0;
      end else if (allocHere) begin
        busyQ[i]  <= 1'b1;
        kindQ[i]  <= allocKind;
        destQ[i]  <= allocDest;
        addrQ[i]  <= allocStoreAddr;
        waitQ[i]  <= allocSrcTag;
        mispQ[i]  <= 1'b0;
        if (allocKind == KIND_STORE) begin
          readyQ[i] <= allocDataValid || issueSnoop;
          valueQ[i] <= allocDataValid ? allocData : cdbValue;
        end else begin
          readyQ[i] <= 1'b0;
        end
      end else if (commitHere) begin
        busyQ[i]  <= 1'b0;
        readyQ[i] <= 1'b0;
      end else if (busyQ[i] && !readyQ[i] && (ownHit || storeHit)) begin
        readyQ[i]  <= 1'b1;
        valueQ[i]  <= cdbValue;
        mispQ[i]   <= ownHit && cdbMispredict;
        targetQ[i] <= cdbTarget;
      end
    end
  end

  logic lookupBypass;
  assign lookupBypass = cdbValid && (cdbTag == lookupTag);
  assign lookupReady  = lookupBypass || (busyQ[lookupTag] && readyQ[lookupTag]);
  assign lookupValue  = lookupBypass ? cdbValue : valueQ[lookupTag];

  assign headBusy       = busyQ[headPtr];
  assign headReady      = readyQ[headPtr];
  assign headKind       = kindQ[headPtr];
  assign headMispredict = mispQ[headPtr];
  assign headDest       = destQ[headPtr];
  assign headValue      = valueQ[headPtr];
  assign headAddr       = addrQ[headPtr];
  assign headTarget     = targetQ[headPtr];

  // R2: the slot handed out must be free
  a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.allocEn |-> !busyQ[tailPtr]);

  // R2: a granted slot is occupied on the next cycle
  a_r2_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.allocEn && !strobe.flushEn |=> busyQ[$past(tailPtr)]);

  // R8: nothing stays occupied after a flush
  a_r8_flush_clears_head: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flushEn |=> !busyQ[headPtr] && !busyQ[tailPtr]);

endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocReq,
  input  logic              rsFree,
  input  logic [1:0]        allocKind,
  input  logic [REG_W-1:0]  allocDest,
  input  logic [ADDR_W-1:0] allocStoreAddr,
  input  logic              allocDataValid,
  input  logic [DATA_W-1:0] allocData,
  input  logic [TAG_W-1:0]  allocSrcTag,
  output logic              allocGrant,
  output logic [TAG_W-1:0]  allocTag,
  output logic              robFull,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic              cdbMispredict,
  input  logic [ADDR_W-1:0] cdbTarget,
  output logic              regWe,
  output logic [REG_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              flush,
  output logic [ADDR_W-1:0] redirectPc
);

  rob_strobe_t      strobe;
  logic [TAG_W-1:0] headPtr, tailPtr;
  logic             headBusy, headReady, headMispredict;
  entry_kind_e      headKind;
  logic [REG_W-1:0] headDest;
  logic [DATA_W-1:0] headValue;
  logic [ADDR_W-1:0] headAddr, headTarget;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst_n, .allocReq, .rsFree,
    .headBusy, .headReady, .headKind, .headMispredict,
    .strobe, .headPtr, .tailPtr, .robFull
  );

  rob_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_data (
    .clk, .rst_n, .strobe, .headPtr, .tailPtr,
    .allocKind(entry_kind_e'(allocKind)), .allocDest, .allocStoreAddr,
    .allocDataValid, .allocData, .allocSrcTag,
    .cdbValid, .cdbTag, .cdbValue, .cdbMispredict, .cdbTarget,
    .lookupTag, .lookupReady, .lookupValue,
    .headBusy, .headReady, .headKind, .headMispredict,
    .headDest, .headValue, .headAddr, .headTarget
  );

  assign allocGrant = strobe.allocEn;
  assign allocTag   = tailPtr;
  assign regWe      = strobe.commitEn && (headKind == KIND_ALU);
  assign regAddr    = headDest;
  assign regData    = headValue;
  assign memWe      = strobe.commitEn && (headKind == KIND_STORE);
  assign memAddr    = headAddr;
  assign memData    = headValue;
  assign flush      = strobe.flushEn;
  assign redirectPc = headTarget;

  // R7: a single retire never produces two different actions
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({regWe, memWe, flush}) <= 1);

endmodule

// File: tb/spec_rob_tb.sv
module spec_rob_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TAG_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        allocReq = 1'b0, rsFree = 1'b1, allocDataValid = 1'b0;
  logic [1:0]  allocKind = 2'b00;
  logic [4:0]  allocDest = '0;
  logic [31:0] allocStoreAddr = '0, allocData = '0;
  logic [TAG_W-1:0] allocSrcTag = '0, lookupTag = '0, cdbTag = '0;
  logic        cdbValid = 1'b0, cdbMispredict = 1'b0;
  logic [31:0] cdbValue = '0, cdbTarget = '0;
  logic        allocGrant, robFull, lookupReady, regWe, memWe, flush;
  logic [TAG_W-1:0] allocTag;
  logic [31:0] lookupValue, regData, memAddr, memData, redirectPc;
  logic [4:0]  regAddr;

  spec_rob u_dut (
    .clk, .rst_n, .allocReq, .rsFree, .allocKind, .allocDest, .allocStoreAddr,
    .allocDataValid, .allocData, .allocSrcTag, .allocGrant, .allocTag, .robFull,
    .lookupTag, .lookupReady, .lookupValue, .cdbValid, .cdbTag, .cdbValue,
    .cdbMispredict, .cdbTarget, .regWe, .regAddr, .regData, .memWe, .memAddr,
    .memData, .flush, .redirectPc
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int          kind;   // 0 register write, 1 memory write, 2 flush
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t sbQ[$];
  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input logic [31:0] a,
                             input logic [31:0] d, input string req);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    sbQ.push_back(e);
  endtask

  // monitor: every retire action is compared with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && (regWe || memWe || flush)) begin
      int k;
      logic [31:0] a, d;
      k = regWe ? 0 : (memWe ? 1 : 2);
      a = regWe ? {27'b0, regAddr} : (memWe ? memAddr : redirectPc);
      d = regWe ? regData : (memWe ? memData : 32'h0);
      if (sbQ.size() == 0) begin
        check(1'b0, "R6", "unexpected retire action kind", k, 32'hffffffff);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(k == e.kind, e.req, "retire kind", k, e.kind);
        check(a == e.addr, e.req, "retire address", a, e.addr);
        check(d == e.data, e.req, "retire data", d, e.data);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // called one time unit after a rising edge; returns at the same phase
  task automatic alloc_op(input logic [1:0] kind, input logic [4:0] dest,
                          input logic [31:0] addr, input bit dv,
                          input logic [31:0] data, input logic [TAG_W-1:0] src,
                          output logic [TAG_W-1:0] tag, output bit granted);
    allocReq = 1'b1; allocKind = kind; allocDest = dest; allocStoreAddr = addr;
    allocDataValid = dv; allocData = data; allocSrcTag = src;
    @(negedge clk);
    tag = allocTag;
    granted = allocGrant;
    @(posedge clk);
    #1;
    allocReq = 1'b0; allocDataValid = 1'b0;
  endtask

  task automatic cdb_send(input logic [TAG_W-1:0] tag, input logic [31:0] val,
                          input bit misp, input logic [31:0] tgt);
    cdbValid = 1'b1; cdbTag = tag; cdbValue = val; cdbMispredict = misp; cdbTarget = tgt;
    @(posedge clk);
    #1;
    cdbValid = 1'b0; cdbMispredict = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "R6", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] tA, tB, tC, tX, tBr, tN1, tN2;
    logic [TAG_W-1:0] full[DEPTH];
    bit g;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(!robFull && !regWe && !memWe && !flush, "R10", "outputs in reset",
          {robFull, regWe, memWe, flush}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!robFull && !regWe && !memWe && !flush, "R10", "outputs after reset",
          {robFull, regWe, memWe, flush}, 0);
    @(posedge clk); #1;

    // R2 / R4 / R3 / R6: out-of-order results, in-order retire
    alloc_op(2'b00, 5'd3, 0, 0, 0, 0, tA, g);
    check(g && tA == 0, "R2", "first tag after reset", tA, 0);
    alloc_op(2'b00, 5'd4, 0, 0, 0, 0, tB, g);
    check(g && tB == 1, "R2", "second tag", tB, 1);
    cdb_send(tB, 32'h0000_00bb, 0, 0);
    lookupTag = tB;
    @(negedge clk);
    check(lookupReady, "R3", "finished producer ready", lookupReady, 1);
    check(lookupValue == 32'hbb, "R4", "captured value via lookup", lookupValue, 32'hbb);
    check(!regWe, "R6", "younger result does not retire first", regWe, 0);
    @(posedge clk); #1;
    expect_item(0, 3, 32'haa, "R6");
    expect_item(0, 4, 32'hbb, "R6");
    cdb_send(tA, 32'h0000_00aa, 0, 0);
    idle(3);

    // R9: broadcast and lookup of the same tag in one cycle
    alloc_op(2'b00, 5'd5, 0, 0, 0, 0, tC, g);
    lookupTag = tC;
    cdbValid = 1'b1; cdbTag = tC; cdbValue = 32'h1234;
    @(negedge clk);
    check(lookupReady && lookupValue == 32'h1234, "R9", "same-cycle bypass",
          lookupValue, 32'h1234);
    expect_item(0, 5, 32'h1234, "R7");
    @(posedge clk); #1;
    cdbValid = 1'b0;
    idle(2);

    // R5 / R7: store with data at issue
    expect_item(1, 32'h100, 32'h55, "R5");
    alloc_op(2'b01, 0, 32'h100, 1, 32'h55, 0, tX, g);
    idle(2);

    // R5: store waits for its producer on the bus
    alloc_op(2'b00, 5'd7, 0, 0, 0, 0, tA, g);
    alloc_op(2'b01, 0, 32'h200, 0, 0, tA, tX, g);
    expect_item(0, 7, 32'h77, "R5");
    expect_item(1, 32'h200, 32'h77, "R5");
    cdb_send(tA, 32'h77, 0, 0);
    idle(3);

    // R5: producer broadcast in the store's allocation cycle
    alloc_op(2'b00, 5'd8, 0, 0, 0, 0, tA, g);
    expect_item(0, 8, 32'h99, "R5");
    expect_item(1, 32'h300, 32'h99, "R5");
    cdbValid = 1'b1; cdbTag = tA; cdbValue = 32'h99;
    alloc_op(2'b01, 0, 32'h300, 0, 0, tA, tX, g);
    cdbValid = 1'b0;
    idle(3);
    check(sbQ.size() == 0, "R5", "stores retired", sbQ.size(), 0);

    // R7: correctly predicted branch retires silently
    alloc_op(2'b10, 0, 0, 0, 0, 0, tBr, g);
    alloc_op(2'b00, 5'd9, 0, 0, 0, 0, tA, g);
    expect_item(0, 9, 32'h9, "R7");
    cdb_send(tA, 32'h9, 0, 0);
    cdb_send(tBr, 0, 0, 32'h8000);
    idle(3);
    check(sbQ.size() == 0, "R7", "branch then normal retired", sbQ.size(), 0);

    // R1 / R2: fill all slots starting from a non-zero pointer
    for (int i = 0; i < DEPTH; i++) begin
      alloc_op(2'b00, 5'(10 + i), 0, 0, 0, 0, full[i], g);
      check(g, "R1", "grant while space", g, 1);
    end
    check(full[0] == 2 && full[6] == 0, "R2", "tag wrap", {full[0], full[6]}, {3'd2, 3'd0});
    @(negedge clk);
    check(robFull, "R1", "full flag", robFull, 1);
    @(posedge clk); #1;
    alloc_op(2'b00, 5'd30, 0, 0, 0, 0, tX, g);
    check(!g, "R1", "no grant when full", g, 0);
    for (int i = 0; i < DEPTH; i++) expect_item(0, 10 + i, 32'h500 + i, "R6");
    for (int i = DEPTH - 1; i >= 0; i--) cdb_send(full[i], 32'h500 + i, 0, 0);
    idle(DEPTH + 2);
    check(sbQ.size() == 0 && !robFull, "R6", "drained in order", sbQ.size(), 0);
    rsFree = 1'b0;
    alloc_op(2'b00, 5'd31, 0, 0, 0, 0, tX, g);
    check(!g, "R1", "no grant without reservation station", g, 0);
    rsFree = 1'b1;

    // R8: mispredicted branch with finished younger slots
    alloc_op(2'b10, 0, 0, 0, 0, 0, tBr, g);
    alloc_op(2'b00, 5'd20, 0, 0, 0, 0, tN1, g);
    alloc_op(2'b00, 5'd21, 0, 0, 0, 0, tN2, g);
    cdb_send(tN1, 32'hdead, 0, 0);
    cdb_send(tN2, 32'hbeef, 0, 0);
    expect_item(2, 32'h4000, 0, "R8");
    cdb_send(tBr, 0, 1, 32'h4000);
    idle(1);
    lookupTag = tN1;
    @(negedge clk);
    check(!lookupReady, "R8", "younger slot discarded", lookupReady, 0);
    check(!robFull && !flush, "R8", "single flush cycle", flush, 0);
    @(posedge clk); #1;
    alloc_op(2'b00, 5'd22, 0, 0, 0, 0, tX, g);
    check(g && tX == 0, "R8", "tag restarts at zero", tX, 0);
    expect_item(0, 22, 32'h22, "R8");
    cdb_send(tX, 32'h22, 0, 0);
    idle(4);
    check(sbQ.size() == 0, "R8", "scoreboard empty at end", sbQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule